// File: doc/BRIEF.md
# Two-Port Write Register File with Fixed Priority

This block is a small bank of general-purpose registers for a datapath that needs to accept two writes per clock. Each of the two write ports carries its own address, data and enable. Each port has its own decoder, which turns that port's address into a one-hot set of load enables. In front of every register sits a two-way data selector that picks which port's data that register takes. When both ports name the same register in one cycle, port A wins. Port A then decides both that the register loads and which data it stores, and port B's write is discarded.

Two read ports return register contents by address through combinational selectors. A read in a given cycle sees the value held before that cycle's clock edge, so a write made in the same cycle becomes visible on the following cycle. A synchronous active-low reset clears every register to zero. By default the block holds eight registers of sixteen bits each.

Top module: `dwp_regfile`

## Requirements
- R1: While rst_n is low at a rising clock edge, every register becomes zero. The next reads of every address return 0.
- R2: When wa_en is high, register wa_addr loads wa_data at the rising edge.
- R3: When wb_en is high and wb_addr differs from port A's enabled target, register wb_addr loads wb_data at the rising edge.
- R4: When both enables are high and wa_addr equals wb_addr, the register stores wa_data, and wb_data is dropped.
- R5: When both ports are enabled for different registers in the same cycle, both writes complete.
- R6: A port whose enable is low changes no register, whatever its address and data.
- R7: rd0_data and rd1_data show the current contents of the registers at rd0_addr and rd1_addr combinationally. A register written at an edge shows its new value only after that edge.
- R8: Registers that no enabled port addresses keep their value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| wa_en | input | 1 | Port A write enable (higher priority) |
| wa_addr | input | 3 | Port A register address |
| wa_data | input | 16 | Port A write data |
| wb_en | input | 1 | Port B write enable |
| wb_addr | input | 3 | Port B register address |
| wb_data | input | 16 | Port B write data |
| rd0_addr | input | 3 | Read port 0 address |
| rd0_data | output | 16 | Read port 0 data |
| rd1_addr | input | 3 | Read port 1 address |
| rd1_data | output | 16 | Read port 1 data |

## Verification
The bench first fills all registers through each port alone, which separates decoding errors on one port from errors on the other. It then sends directed collisions, where both ports target the same address with different data. Only a correct priority selector stores port A's value in that case. Split-address dual writes show that port B is not blocked when there is no conflict. Disabled-port writes with live address and data show that the enables really gate the decoders. A long pseudo-random phase mixes all of these cases while both read ports are compared against a behavioural model on every cycle, including reads of the address being written in that cycle.

// File: rtl/dwp_regfile_pkg.sv
// Shared sizing for the dual-write register file.
// Assumes NREGS is a power of two.
package dwp_regfile_pkg;
    localparam int unsigned NREGS = 8;
    localparam int unsigned DW    = 16;
    localparam int unsigned AW    = $clog2(NREGS);
endpackage

// File: rtl/dwp_wdec.sv
// Write address decoder: gives a one-hot load vector when enabled and all zeros otherwise.
// Assumes addr < N.
module dwp_wdec #(
    parameter int unsigned N  = 8,
    parameter int unsigned AW = $clog2(N)
) (
    input  logic          en,
    input  logic [AW-1:0] addr,
    output logic [N-1:0]  sel
);
    // Decode the address into one load line, gated by the port enable.
    always_comb begin
        sel = '0;
        for (int i = 0; i < N; i++) begin
            if (en && (addr == AW'(i))) sel[i] = 1'b1;
        end
    end

    // R6: with the enable low, no load line may be active.
    always_comb begin
        assert_off_quiet_R6: assert (en || sel == '0);
        assert_onehot_R2: assert ($onehot0(sel));
    end
endmodule

// File: rtl/dwp_rdmux.sv
// Combinational read selector over the flattened register array.
// Assumes addr < N.
module dwp_rdmux #(
    parameter int unsigned N  = 8,
    parameter int unsigned DW = 16,
    parameter int unsigned AW = $clog2(N)
) (
    input  logic [N*DW-1:0] regs_flat,
    input  logic [AW-1:0]   addr,
    output logic [DW-1:0]   data
);
    // Select one register slice by address.
    always_comb begin
        data = '0;
        for (int i = 0; i < N; i++) begin
            if (addr == AW'(i)) data = regs_flat[i*DW +: DW];
        end
    end
endmodule

// File: rtl/dwp_cell.sv
// One storage register with its port selector: port A data has priority whenever port A selects this register.
// Assumes a synchronous active-low reset.
module dwp_cell #(
    parameter int unsigned DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ld_a,
    input  logic          ld_b,
    input  logic [DW-1:0] da,
    input  logic [DW-1:0] db,
    output logic [DW-1:0] q
);
    logic [DW-1:0] d_sel;

    // The data selector picks port A when A loads this register, and port B otherwise.
    always_comb d_sel = ld_a ? da : db;

    // Load-enabled edge-triggered storage with synchronous clear.
    always_ff @(posedge clk) begin
        if (!rst_n)             q <= '0;
        else if (ld_a || ld_b)  q <= d_sel;
    end

    assert_clear_R1: assert property (@(posedge clk) !rst_n |=> q == '0);
    assert_prio_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_a && ld_b) |=> q == $past(da));
    assert_b_only_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!ld_a && ld_b) |=> q == $past(db));
    assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!ld_a && !ld_b) |=> $stable(q));
endmodule

// File: rtl/dwp_regfile.sv
// Top: register file with two write ports (A beats B on a collision) and two combinational read ports.
// Assumes synchronous active-low reset and in-range addresses.
module dwp_regfile
    import dwp_regfile_pkg::*;
#(
    parameter int unsigned N_REG  = NREGS,
    parameter int unsigned D_W    = DW,
    parameter int unsigned A_W    = $clog2(N_REG)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           wa_en,
    input  logic [A_W-1:0] wa_addr,
    input  logic [D_W-1:0] wa_data,
    input  logic           wb_en,
    input  logic [A_W-1:0] wb_addr,
    input  logic [D_W-1:0] wb_data,
    input  logic [A_W-1:0] rd0_addr,
    output logic [D_W-1:0] rd0_data,
    input  logic [A_W-1:0] rd1_addr,
    output logic [D_W-1:0] rd1_data
);
    logic [N_REG-1:0]     sel_a, sel_b;
    logic [N_REG*D_W-1:0] regs_flat;

    dwp_wdec #(.N(N_REG), .AW(A_W)) u_dec_a (.en(wa_en), .addr(wa_addr), .sel(sel_a));
    dwp_wdec #(.N(N_REG), .AW(A_W)) u_dec_b (.en(wb_en), .addr(wb_addr), .sel(sel_b));

    for (genvar g = 0; g < N_REG; g++) begin : g_cell
        dwp_cell #(.DW(D_W)) u_cell (
            .clk   (clk),
            .rst_n (rst_n),
            .ld_a  (sel_a[g]),
            .ld_b  (sel_b[g]),
            .da    (wa_data),
            .db    (wb_data),
            .q     (regs_flat[g*D_W +: D_W])
        );
    end

    dwp_rdmux #(.N(N_REG), .DW(D_W), .AW(A_W)) u_rd0 (
        .regs_flat(regs_flat), .addr(rd0_addr), .data(rd0_data));
    dwp_rdmux #(.N(N_REG), .DW(D_W), .AW(A_W)) u_rd1 (
        .regs_flat(regs_flat), .addr(rd1_addr), .data(rd1_data));

    // R2 and R7: a port A write is seen on a read port of the same address one cycle later.
    assert_a_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wa_en && rd0_addr == wa_addr) ##1 (rd0_addr == $past(wa_addr)) |-> rd0_data == $past(wa_data));
    // R5: writes to different addresses both land.
    assert_dual_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (wa_en && wb_en && wa_addr != wb_addr && rd1_addr == wb_addr) ##1 (rd1_addr == $past(wb_addr))
        |-> rd1_data == $past(wb_data));
endmodule

// File: tb/sim_dwp_regfile.sv
module sim_dwp_regfile;
    localparam int N = 8;
    logic        clk = 0, rst_n = 0;
    logic        wa_en = 0, wb_en = 0;
    logic [2:0]  wa_addr = 0, wb_addr = 0, rd0_addr = 0, rd1_addr = 0;
    logic [15:0] wa_data = 0, wb_data = 0;
    logic [15:0] rd0_data, rd1_data;
    int          checks = 0, fails = 0;
    logic [15:0] model [N];
    bit          done = 0;

    always #4 clk = ~clk;

    dwp_regfile u0 (.clk(clk), .rst_n(rst_n), .wa_en(wa_en), .wa_addr(wa_addr), .wa_data(wa_data),
        .wb_en(wb_en), .wb_addr(wb_addr), .wb_data(wb_data), .rd0_addr(rd0_addr), .rd0_data(rd0_data),
        .rd1_addr(rd1_addr), .rd1_data(rd1_data));

    task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Reference update, applied at each rising edge (R1..R6, R8).
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < N; i++) model[i] <= '0;
        end else begin
            if (wb_en) model[wb_addr] <= wb_data;
            if (wa_en) model[wa_addr] <= wa_data; // A last: wins on collision (R4)
        end
    end

    // Compare both read ports every cycle at the falling edge (R7).
    always @(negedge clk) if (rst_n && !done) begin
        chk("R7 rd0", rd0_data, model[rd0_addr]);
        chk("R7 rd1", rd1_data, model[rd1_addr]);
    end

    task automatic cyc(bit ae, int aa, int ad, bit be, int ba, int bd, int r0, int r1);
        @(posedge clk); #1;
        wa_en = ae; wa_addr = 3'(aa); wa_data = 16'(ad);
        wb_en = be; wb_addr = 3'(ba); wb_data = 16'(bd);
        rd0_addr = 3'(r0); rd1_addr = 3'(r1);
    endtask

    task automatic peek(string req, int a, logic [15:0] exp);
        cyc(0, 0, 0, 0, 0, 0, a, a);
        #2; chk(req, rd0_data, exp); chk(req, rd1_data, exp);
    endtask

    initial begin
        fork begin
            #2000000;
            fails++; checks++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end join_none
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        for (int i = 0; i < N; i++) peek("R1 reset zero", i, 16'h0);
        for (int i = 0; i < N; i++) cyc(1, i, 16'h1100 + i, 0, 0, 0, i, 0);       // R2
        for (int i = 0; i < N; i++) peek("R2 port A write", i, 16'h1100 + 16'(i));
        for (int i = 0; i < N; i++) cyc(0, 0, 0, 1, i, 16'h2200 + i, 0, i);       // R3
        for (int i = 0; i < N; i++) peek("R3 port B write", i, 16'h2200 + 16'(i));
        cyc(1, 3, 16'hAAAA, 1, 3, 16'hBBBB, 3, 3);
        #2; chk("R7 pre-edge value", rd0_data, 16'h2203);
        peek("R4 collision A wins", 3, 16'hAAAA);
        cyc(1, 1, 16'h0A01, 1, 6, 16'h0B06, 1, 6);
        peek("R5 dual A", 1, 16'h0A01);
        peek("R5 dual B", 6, 16'h0B06);
        cyc(0, 2, 16'hDEAD, 0, 5, 16'hBEEF, 2, 5);
        peek("R6 disabled A", 2, 16'h2202);
        peek("R6 disabled B", 5, 16'h2205);
        peek("R8 untouched", 7, 16'h2207);
        for (int k = 0; k < 3000; k++)
            cyc(1'($urandom), $urandom % 8, $urandom, 1'($urandom), $urandom % 8, $urandom,
                $urandom % 8, $urandom % 8);
        cyc(0, 0, 0, 0, 0, 0, 0, 0);
        @(posedge clk); #1 rst_n = 0;
        @(posedge clk); #1 rst_n = 1;
        for (int i = 0; i < N; i++) peek("R1 reset after use", i, 16'h0);
        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule